// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes of one parallel ATA channel. The strobe timing comes from a packed 32-bit per-device timing word that the block holds. A request carries a direction and an access kind: a data transfer or a task-file register access. The kind picks which set of timing fields applies.

After an idle period, an accepted request first spends a setup interval with both strobes high. The selected strobe is then held low for the active time. After that both strobes stay high for the recovery time, and a one-cycle done pulse marks the last cycle of recovery. If a request is waiting in that last cycle, it starts its active phase on the very next cycle with no setup interval.

The timing word is changed by a masked write. The mode class given with the write decides which bits are replaced, so that PIO, multiword DMA and UDMA settings can be programmed independently into the same word.

Top module: `ata_strobe_gen`

## Requirements
- R1: Out of reset both strobes are high, busy and done are low, and the timing word equals the RESET_WORD parameter (default 0).
- R2: A data access holds its strobe low for (bits 8:4)+1 cycles and recovers for (bits 3:0)+1 cycles. With word 0x06414e31 that is 4 active cycles and 2 recovery cycles.
- R3: A task-file access holds its strobe low for (bits 17:13)+1 cycles and recovers for (bits 12:9)+1 cycles.
- R4: A request accepted from idle first spends N cycles with both strobes high and busy high. N is bits 24:22 for data accesses and bits 27:25 for task-file accesses. N = 0 means there is no setup interval.
- R5: A request present in the done cycle is accepted, and its strobe goes low on the next cycle with no setup interval.
- R6: A write request (reqWrite=1) drives only wrStrobeN low, and a read drives only rdStrobeN low. The two strobes are never low together.
- R7: While busy is high, requests are ignored and have no effect on the strobes or on the access in progress.
- R8: done is a one-cycle pulse in the last recovery cycle. busy is low in that cycle and high in every other cycle of an access.
- R9: A write with cfgWe=1 replaces only the bits in a class mask: class 0 (PIO) 0xcfc3ffff, class 1 (multiword DMA) 0x31c001ff, class 2 (UDMA) 0x303c0000, class 3 no bits. The new word is visible on the next cycle.
- R10: The timing fields of an access are fixed when it is accepted. A register write made in the accept cycle or later does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Timing word write enable |
| cfgClass | input | 2 | Mode class that selects the write mask |
| cfgWord | input | 32 | Timing word write data |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write strobe, 0 = read strobe |
| reqTaskFile | input | 1 | 1 = task-file timing, 0 = data timing |
| timingWord | output | 32 | Current timing word |
| rdStrobeN | output | 1 | Active-low read strobe |
| wrStrobeN | output | 1 | Active-low write strobe |
| busy | output | 1 | Access in progress; requests ignored |
| done | output | 1 | Last recovery cycle pulse |

## Verification
Two functions can fall in the same cycle. The first pair is a register write and the acceptance of a request. The second pair is the done cycle and a new request. The bench holds reqValid through the done cycle to judge the second-cycle active start, and it drives a masked write together with a request and during the setup phase. In both cases it checks that the strobe lengths follow the word as it stood at acceptance, while the timing word output already shows the update.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  localparam int WORD_W = 32;
  localparam int PRE_W  = 3;
  localparam int ACT_W  = 5;
  localparam int REC_W  = 4;
  localparam int CNT_W  = ACT_W;

  localparam logic [WORD_W-1:0] MASK_PIO  = 32'hcfc3ffff;
  localparam logic [WORD_W-1:0] MASK_MDMA = 32'h31c001ff;
  localparam logic [WORD_W-1:0] MASK_UDMA = 32'h303c0000;

  typedef enum logic [1:0] {CLS_PIO, CLS_MDMA, CLS_UDMA, CLS_NONE} modeClass_t;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [ACT_W-1:0] act;
    logic [REC_W-1:0] rec;
  } phaseTimes_t;

  typedef struct packed {
    logic accept;
    logic ldPre;
    logic ldAct;
    logic ldRec;
    logic active;
  } ctlStrobes_t;

  function automatic phaseTimes_t pickTimes(logic [WORD_W-1:0] w, logic taskFile);
    phaseTimes_t t;
    if (taskFile) begin
      t.pre = w[27:25];
      t.act = w[17:13];
      t.rec = w[12:9];
    end else begin
      t.pre = w[24:22];
      t.act = w[8:4];
      t.rec = w[3:0];
    end
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] classMask(modeClass_t c);
    case (c)
      CLS_PIO:  return MASK_PIO;
      CLS_MDMA: return MASK_MDMA;
      CLS_UDMA: return MASK_UDMA;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
  import ata_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        preZero,
  input  logic        cntZero,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACT, ST_REC} phase_t;
  phase_t state, stateNext;
  logic accept;

  assign done   = (state == ST_REC) && cntZero;
  assign busy   = (state != ST_IDLE) && !done;
  assign accept = reqValid && !busy;

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    ctl.accept = accept;
    ctl.active = (state == ST_ACT);
    case (state)
      ST_IDLE: if (accept) begin
        if (preZero) begin stateNext = ST_ACT; ctl.ldAct = 1'b1; end
        else begin stateNext = ST_PRE; ctl.ldPre = 1'b1; end
      end
      ST_PRE: if (cntZero) begin stateNext = ST_ACT; ctl.ldAct = 1'b1; end
      ST_ACT: if (cntZero) begin stateNext = ST_REC; ctl.ldRec = 1'b1; end
      ST_REC: if (cntZero) begin
        if (accept) begin stateNext = ST_ACT; ctl.ldAct = 1'b1; end
        else stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/strobe_dp.sv
module strobe_dp
  import ata_strobe_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              cfgWe,
  input  logic [1:0]        cfgClass,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic              reqWrite,
  input  logic              reqTaskFile,
  output logic [WORD_W-1:0] timingWord,
  output logic              preZero,
  output logic              cntZero,
  output logic              rdStrobeN,
  output logic              wrStrobeN
);
  logic [WORD_W-1:0] timingReg;
  logic [WORD_W-1:0] wrMask;
  phaseTimes_t liveTimes, heldTimes, useTimes;
  logic [CNT_W-1:0] cnt;
  logic dirWriteQ;

  assign wrMask    = classMask(modeClass_t'(cfgClass));
  assign liveTimes = pickTimes(timingReg, reqTaskFile);
  assign useTimes  = ctl.accept ? liveTimes : heldTimes;
  assign preZero   = (liveTimes.pre == '0);
  assign cntZero   = (cnt == '0);
  assign timingWord = timingReg;
  assign rdStrobeN = !(ctl.active && !dirWriteQ);
  assign wrStrobeN = !(ctl.active && dirWriteQ);

  always_ff @(posedge clk) begin
    if (!rstN) timingReg <= RESET_WORD;
    else if (cfgWe) timingReg <= (timingReg & ~wrMask) | (cfgWord & wrMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldTimes <= '0;
      dirWriteQ <= 1'b0;
    end else if (ctl.accept) begin
      heldTimes <= liveTimes;
      dirWriteQ <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (ctl.ldPre) cnt <= CNT_W'(useTimes.pre) - CNT_W'(1);
    else if (ctl.ldAct) cnt <= CNT_W'(useTimes.act);
    else if (ctl.ldRec) cnt <= CNT_W'(useTimes.rec);
    else if (!cntZero)  cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgClass,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqTaskFile,
  output logic [WORD_W-1:0] timingWord,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic              busy,
  output logic              done
);
  ctlStrobes_t ctl;
  logic preZero, cntZero;

  strobe_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .preZero(preZero),
    .cntZero(cntZero), .ctl(ctl), .busy(busy), .done(done)
  );

  strobe_dp #(.RESET_WORD(RESET_WORD)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgWe(cfgWe), .cfgClass(cfgClass),
    .cfgWord(cfgWord), .reqWrite(reqWrite), .reqTaskFile(reqTaskFile),
    .timingWord(timingWord), .preZero(preZero), .cntZero(cntZero),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN)
  );
endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk
  import ata_strobe_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [1:0]        cfgClass,
  input logic [WORD_W-1:0] timingWord,
  input logic              rdStrobeN,
  input logic              wrStrobeN,
  input logic              busy,
  input logic              done
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobeN || wrStrobeN)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8
  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> (rdStrobeN && wrStrobeN)); // R1
  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobeN || !wrStrobeN) |-> busy); // R7
  AST_PIO_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgClass == 2'd0) |=> (((timingWord ^ $past(timingWord)) & ~MASK_PIO) == '0)); // R9
  AST_NONE_CLASS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgClass == 2'd3) |=> $stable(timingWord)); // R9
endmodule

bind ata_strobe_gen ata_strobe_chk uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgClass(cfgClass),
  .timingWord(timingWord), .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
  .busy(busy), .done(done)
);

// File: tb/tb_ata_strobe_gen.sv
`timescale 1ns/1ps
module tb_ata_strobe_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgClass = 2'd0;
  logic [31:0] cfgWord = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqTaskFile = 1'b0;
  logic [31:0] timingWord;
  logic rdStrobeN, wrStrobeN, busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ata_strobe_gen dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgClass(cfgClass), .cfgWord(cfgWord),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqTaskFile(reqTaskFile),
    .timingWord(timingWord), .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 setup, 2 active, 3 recovery
  int mPhase = 0, mLeft = 0, mAct = 0, mRec = 0;
  bit mWr = 0;
  logic [31:0] mReg = '0;

  function automatic logic [31:0] maskOf(input int c);
    if (c == 0) return 32'hcfc3ffff;
    if (c == 1) return 32'h31c001ff;
    if (c == 2) return 32'h303c0000;
    return 32'h0;
  endfunction

  function automatic bit mBusy();
    return (mPhase != 0) && !(mPhase == 3 && mLeft == 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mLeft = 0; mReg = '0;
    end else begin
      bit acc;
      int p, a, r;
      acc = reqValid && !mBusy();
      p = reqTaskFile ? int'(mReg[27:25]) : int'(mReg[24:22]);
      a = reqTaskFile ? int'(mReg[17:13]) : int'(mReg[8:4]);
      r = reqTaskFile ? int'(mReg[12:9])  : int'(mReg[3:0]);
      if (mPhase == 0) begin
        if (acc) begin
          mWr = reqWrite; mAct = a; mRec = r;
          if (p == 0) begin mPhase = 2; mLeft = a + 1; end
          else begin mPhase = 1; mLeft = p; end
        end
      end else if (mLeft > 1) begin
        mLeft--;
      end else begin
        case (mPhase)
          1: begin mPhase = 2; mLeft = mAct + 1; end
          2: begin mPhase = 3; mLeft = mRec + 1; end
          default: begin
            if (acc) begin
              mWr = reqWrite; mAct = a; mRec = r;
              mPhase = 2; mLeft = a + 1;
            end else mPhase = 0;
          end
        endcase
      end
      if (cfgWe) mReg = (mReg & ~maskOf(int'(cfgClass))) | (cfgWord & maskOf(int'(cfgClass)));
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R6", "rdStrobeN", rdStrobeN, !(mPhase == 2 && !mWr));
      check("R6", "wrStrobeN", wrStrobeN, !(mPhase == 2 && mWr));
      check("R7", "busy", busy, mBusy());
      check("R8", "done", done, (mPhase == 3 && mLeft == 1));
      check("R9", "timingWord", timingWord, mReg);
    end
  end

  task automatic writeCfg(input int cls, input logic [31:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgClass = 2'(cls); cfgWord = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one request from idle; counts setup, strobe-low and recovery samples
  task automatic runAccess(input bit w, input bit tf, output int preN, output int lowN,
                           output int recN, output int otherLow);
    preN = 0; lowN = 0; recN = 0; otherLow = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqTaskFile = tf;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 120; i++) begin
      if ((w ? wrStrobeN : rdStrobeN) == 1'b0) lowN++;
      else if (lowN == 0) preN++;
      else recN++;
      if ((w ? rdStrobeN : wrStrobeN) == 1'b0) otherLow++;
      if (done) break;
      @(negedge clk);
    end
  endtask

  initial begin
    int preN, lowN, recN, otherLow;
    repeat (3) @(negedge clk);
    check("R1", "reset rdStrobeN", rdStrobeN, 1);
    check("R1", "reset wrStrobeN", wrStrobeN, 1);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset done", done, 0);
    check("R1", "reset timingWord", timingWord, 0);
    rstN = 1'b1;

    // R2 data read with the PIO example word
    writeCfg(0, 32'h06414e31);
    check("R9", "pio write", timingWord, 32'h06414e31);
    runAccess(1'b0, 1'b0, preN, lowN, recN, otherLow);
    check("R2", "data active cycles", lowN, 4);
    check("R2", "data recovery cycles", recN, 2);
    check("R4", "data setup cycles", preN, 1);
    check("R6", "write strobe during read", otherLow, 0);

    // R3 task-file write
    runAccess(1'b1, 1'b1, preN, lowN, recN, otherLow);
    check("R3", "taskfile active cycles", lowN, 11);
    check("R3", "taskfile recovery cycles", recN, 8);
    check("R4", "taskfile setup cycles", preN, 3);
    check("R6", "read strobe during write", otherLow, 0);

    // R9 class masks
    writeCfg(1, 32'hffffffff);
    check("R9", "mdma mask", timingWord, 32'h37c14fff);
    writeCfg(2, 32'h00000000);
    check("R9", "udma mask", timingWord, 32'h07c14fff);
    writeCfg(3, 32'h00000000);
    check("R9", "class3 no change", timingWord, 32'h07c14fff);

    // R4 zero setup: data pre=0, act=2 (3 cycles), rec=1 (2 cycles)
    writeCfg(0, 32'h00000021);
    runAccess(1'b1, 1'b0, preN, lowN, recN, otherLow);
    check("R4", "zero setup", preN, 0);
    check("R2", "short active", lowN, 3);

    // R5 back-to-back with reqValid held; R7 extra requests ignored while busy
    writeCfg(0, 32'h00800011);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqTaskFile = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) begin
        reqWrite = 1'b1;
        @(negedge clk);
        check("R5", "strobe low right after done", wrStrobeN, 0);
        break;
      end
    end
    reqValid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) break;
    end
    @(negedge clk);
    check("R7", "idle after held-off requests", busy, 0);

    // R10 write in the accept cycle and during setup does not change the access
    writeCfg(0, 32'h00c00010);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqTaskFile = 1'b0;
    cfgWe = 1'b1; cfgClass = 2'd0; cfgWord = 32'h004000f0;
    @(negedge clk);
    reqValid = 1'b0; cfgWord = 32'h004001f0;
    @(negedge clk);
    cfgWe = 1'b0;
    lowN = 0;
    for (int i = 0; i < 60; i++) begin
      if (!rdStrobeN) lowN++;
      if (done) break;
      @(negedge clk);
    end
    check("R10", "active length fixed at accept", lowN, 2);
    check("R10", "word updated meanwhile", timingWord, 32'h004001f0);

    // mixed stimulus, judged by the reference on every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      reqValid = ($urandom_range(0, 3) != 0);
      reqWrite = $urandom_range(0, 1);
      reqTaskFile = $urandom_range(0, 1);
      cfgWe = ($urandom_range(0, 15) == 0);
      cfgClass = 2'($urandom_range(0, 3));
      cfgWord = $urandom() & 32'hf0c3e7ff;
    end
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b0;
    repeat (80) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule